// File: doc/BRIEF.md
# Halfword Fetch Realigner

This block sits between the program counter and a word-wide instruction memory in a core that mixes 16-bit compressed and 32-bit instructions. Memory only ever sees word-aligned addresses. When the PC is word-aligned, the block fetches that word and forwards it. When the PC points at the upper halfword of a word, it inspects that halfword first.

A compressed halfword goes straight through, zero-extended. A halfword that begins a 32-bit instruction starts a two-cycle split fetch:

- It keeps the halfword in a holding register.
- It raises a PC-hold request for that cycle.
- It places a bubble (the canonical no-op) in the output register.
- In the following cycle it fetches the next aligned word and emits the rebuilt instruction {new[15:0], kept[15:0]}.

The output instruction, its valid bit and its compressed flag are registered, which forms the boundary to decode. The fetch address and the PC-hold request are combinational, so they act within the cycle. Stall freezes the block. Flush drops any half-finished split and puts a bubble on the output.

Top module: `fetch_realigner`

## Requirements
- R1: After synchronous reset, insn_o is 32'h00000013, insn_valid_o and insn_comp_o are 0, pc_hold_o is 0 and the block is idle.
- R2: imem_addr_o always has bits [1:0] equal to zero. Outside the second cycle of a split fetch it equals pc_i with bits [1:0] cleared.
- R3: With pc_i[1]=0 and no stall or flush, the fetched word appears on insn_o one clock later, with insn_valid_o=1. Every such cycle delivers one instruction.
- R4: With pc_i[1]=1 in the idle state, when bits [17:16] of the fetched word are not 2'b11, insn_o becomes {16'h0000, word[31:16]} one clock later with insn_valid_o=1. pc_hold_o stays 0.
- R5: With pc_i[1]=1 in the idle state, when word[17:16] is 2'b11, pc_hold_o is 1 in that same cycle. One clock later insn_o is 32'h00000013 with insn_valid_o=0.
- R6: In the cycle after R5, imem_addr_o is the aligned PC plus 4 and pc_hold_o is 0. One clock later insn_o is {word[15:0], kept} with insn_valid_o=1, where kept is the upper halfword saved in R5.
- R7: insn_comp_o is 1 exactly when insn_valid_o is 1 and insn_o[1:0] is not 2'b11.
- R8: flush_i in any state returns the block to idle, deasserts pc_hold_o and loads a bubble (32'h00000013, valid 0) on the next clock. A kept halfword is discarded.
- R9: stall_i without flush_i keeps insn_o, insn_valid_o, insn_comp_o and the split state unchanged, with pc_hold_o at 0. Flush takes priority over stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pc_i | input | ADDR_W | Current program counter (halfword granular) |
| fetch_word_i | input | 32 | Word read from instruction memory at imem_addr_o, same cycle |
| stall_i | input | 1 | Freeze the fetch boundary |
| flush_i | input | 1 | Redirect: abandon any split fetch and emit a bubble |
| imem_addr_o | output | ADDR_W | Word-aligned address to instruction memory |
| insn_o | output | 32 | Registered instruction to decode |
| insn_valid_o | output | 1 | 1 for a real instruction, 0 for a bubble |
| insn_comp_o | output | 1 | Delivered instruction is a 16-bit encoding |
| pc_hold_o | output | 1 | Keep the PC unchanged for the next cycle |

## Verification
The risky overlap is a flush that arrives in the same cycle as the second half of a split fetch. The stitched instruction would then load in the same cycle that the redirect should discard it. The bench starts a split at a misaligned PC, drives flush on the completion cycle, and expects a bubble with valid low rather than the rebuilt word. It then repeats the split at the same PC to confirm that no stale halfword survives. Stall and flush are also driven together, and flush must win.

// File: rtl/fetch_realign_pkg.sv
package fetch_realign_pkg;
  localparam int INSN_W = 32;
  localparam int HALF_W = INSN_W / 2;
  localparam logic [INSN_W-1:0] BUBBLE_INSN = 32'h0000_0013;

  typedef enum logic {
    RA_IDLE   = 1'b0,
    RA_SECOND = 1'b1
  } ra_state_e;

  // An encoding whose two low bits are 2'b11 is a full-width instruction
  function automatic logic is_wide(input logic [1:0] low_bits);
    return low_bits == 2'b11;
  endfunction
endpackage

// File: rtl/ra_addr_gen.sv
module ra_addr_gen #(
  parameter int ADDR_W = 32
) (
  input  logic [ADDR_W-1:0] pc,
  input  logic              second_half,
  output logic [ADDR_W-1:0] addr
);
  localparam logic [ADDR_W-1:0] WORD_BYTES = ADDR_W'(4);

  logic [ADDR_W-1:0] base;

  // R2: memory never sees a sub-word offset
  assign base = {pc[ADDR_W-1:2], 2'b00};
  assign addr = second_half ? base + WORD_BYTES : base;
endmodule

// File: rtl/ra_split_ctrl.sv
module ra_split_ctrl
  import fetch_realign_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              pc_upper,
  input  logic [INSN_W-1:0] word,
  input  logic              stall,
  input  logic              flush,
  output logic              second_half,
  output logic              hold,
  output logic [INSN_W-1:0] asm_insn,
  output logic              asm_valid,
  output logic              asm_comp
);
  ra_state_e         state_q, state_d;
  logic [HALF_W-1:0] kept_q;
  logic              upper_wide;
  logic              advance;

  assign upper_wide  = is_wide(word[HALF_W+1:HALF_W]);
  assign advance     = !stall && !flush;
  assign second_half = (state_q == RA_SECOND);

  // R5: request a PC hold only when a split fetch actually starts
  assign hold = advance && (state_q == RA_IDLE) && pc_upper && upper_wide;

  always_comb begin
    state_d = state_q;
    if (flush) begin
      state_d = RA_IDLE;                     // R8
    end else if (!stall) begin
      unique case (state_q)
        RA_IDLE:   if (pc_upper && upper_wide) state_d = RA_SECOND;
        RA_SECOND: state_d = RA_IDLE;
        default:   state_d = RA_IDLE;
      endcase
    end
  end

  always_comb begin
    asm_insn  = word;                        // R3 aligned pass-through
    asm_valid = 1'b1;
    if (flush) begin
      asm_insn  = BUBBLE_INSN;
      asm_valid = 1'b0;
    end else if (state_q == RA_SECOND) begin
      asm_insn  = {word[HALF_W-1:0], kept_q}; // R6
    end else if (pc_upper) begin
      if (upper_wide) begin
        asm_insn  = BUBBLE_INSN;             // R5
        asm_valid = 1'b0;
      end else begin
        asm_insn  = {{HALF_W{1'b0}}, word[INSN_W-1:HALF_W]}; // R4
      end
    end
  end

  assign asm_comp = asm_valid && !is_wide(asm_insn[1:0]); // R7

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= RA_IDLE;
      kept_q  <= '0;
    end else begin
      state_q <= state_d;
      if (flush)
        kept_q <= '0;
      else if (hold)
        kept_q <= word[INSN_W-1:HALF_W];
    end
  end
endmodule

// File: rtl/ra_out_reg.sv
module ra_out_reg
  import fetch_realign_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [INSN_W-1:0] d_insn,
  input  logic              d_valid,
  input  logic              d_comp,
  output logic [INSN_W-1:0] q_insn,
  output logic              q_valid,
  output logic              q_comp
);
  always_ff @(posedge clk) begin
    if (rst) begin
      q_insn  <= BUBBLE_INSN;                // R1
      q_valid <= 1'b0;
      q_comp  <= 1'b0;
    end else if (load) begin
      q_insn  <= d_insn;
      q_valid <= d_valid;
      q_comp  <= d_comp;
    end
  end
endmodule

// File: rtl/fetch_realigner.sv
module fetch_realigner
  import fetch_realign_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] pc_i,
  input  logic [31:0]       fetch_word_i,
  input  logic              stall_i,
  input  logic              flush_i,
  output logic [ADDR_W-1:0] imem_addr_o,
  output logic [31:0]       insn_o,
  output logic              insn_valid_o,
  output logic              insn_comp_o,
  output logic              pc_hold_o
);
  logic              second_half;
  logic [INSN_W-1:0] asm_insn;
  logic              asm_valid;
  logic              asm_comp;

  ra_addr_gen #(.ADDR_W(ADDR_W)) u_addr (
    .pc          (pc_i),
    .second_half (second_half),
    .addr        (imem_addr_o)
  );

  ra_split_ctrl u_ctrl (
    .clk         (clk),
    .rst         (rst),
    .pc_upper    (pc_i[1]),
    .word        (fetch_word_i),
    .stall       (stall_i),
    .flush       (flush_i),
    .second_half (second_half),
    .hold        (pc_hold_o),
    .asm_insn    (asm_insn),
    .asm_valid   (asm_valid),
    .asm_comp    (asm_comp)
  );

  // R9: flush overrides stall for the decode boundary
  ra_out_reg u_out (
    .clk     (clk),
    .rst     (rst),
    .load    (flush_i || !stall_i),
    .d_insn  (asm_insn),
    .d_valid (asm_valid),
    .d_comp  (asm_comp),
    .q_insn  (insn_o),
    .q_valid (insn_valid_o),
    .q_comp  (insn_comp_o)
  );
endmodule

// File: rtl/fetch_realigner_chk.sv
module fetch_realigner_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] pc_i,
  input logic [31:0]       fetch_word_i,
  input logic              stall_i,
  input logic              flush_i,
  input logic [ADDR_W-1:0] imem_addr_o,
  input logic [31:0]       insn_o,
  input logic              insn_valid_o,
  input logic              insn_comp_o,
  input logic              pc_hold_o
);
  p_addr_aligned_r2: assert property (@(posedge clk) disable iff (rst)
    imem_addr_o[1:0] == 2'b00);

  p_hold_gives_bubble_r5: assert property (@(posedge clk) disable iff (rst)
    (pc_hold_o && !stall_i && !flush_i) |=> (!insn_valid_o && insn_o == 32'h0000_0013));

  p_second_addr_r6: assert property (@(posedge clk) disable iff (rst)
    (pc_hold_o && !stall_i && !flush_i && $stable(pc_i)) |=>
      (!pc_hold_o && imem_addr_o == $past(imem_addr_o) + ADDR_W'(4)));

  p_comp_flag_r7: assert property (@(posedge clk) disable iff (rst)
    insn_comp_o == (insn_valid_o && insn_o[1:0] != 2'b11));

  p_flush_bubble_r8: assert property (@(posedge clk) disable iff (rst)
    flush_i |=> (!insn_valid_o && insn_o == 32'h0000_0013));

  p_flush_no_hold_r8: assert property (@(posedge clk) disable iff (rst)
    flush_i |-> !pc_hold_o);

  p_stall_freeze_r9: assert property (@(posedge clk) disable iff (rst)
    (stall_i && !flush_i) |=> ($stable(insn_o) && $stable(insn_valid_o) && $stable(insn_comp_o)));
endmodule

bind fetch_realigner fetch_realigner_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/sim_fetch_realigner.sv
module sim_fetch_realigner;
  localparam int AW = 32;
  localparam logic [31:0] NOP = 32'h0000_0013;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [AW-1:0] pc = '0;
  logic [31:0]   word;
  logic          stall = 1'b0;
  logic          flush = 1'b0;
  logic [AW-1:0] addr;
  logic [31:0]   insn;
  logic          vld;
  logic          comp;
  logic          hold;

  logic [31:0] mem [16];
  assign word = mem[addr[5:2]];

  always #4 clk = ~clk;

  fetch_realigner #(.ADDR_W(AW)) u0 (
    .clk(clk), .rst(rst), .pc_i(pc), .fetch_word_i(word),
    .stall_i(stall), .flush_i(flush), .imem_addr_o(addr),
    .insn_o(insn), .insn_valid_o(vld), .insn_comp_o(comp), .pc_hold_o(hold)
  );

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  typedef struct packed { logic [31:0] i; logic v; logic c; } exp_t;
  exp_t q[$];
  string tagq[$];
  exp_t last;

  // reference model state
  bit          m_second = 1'b0;
  logic [15:0] m_kept = '0;
  bit          saw_hold;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // driver: one fetch cycle, scoreboard entry for the next clock
  task automatic step(input logic [31:0] p, input bit st, input bit fl, input string tag);
    logic [31:0] ea, w;
    bit eh, wide;
    exp_t e;
    @(negedge clk);
    pc = p; stall = st; flush = fl;
    #1;
    ea = {p[31:2], 2'b00} + (m_second ? 32'd4 : 32'd0);
    w = mem[ea[5:2]];
    wide = (w[17:16] == 2'b11);
    eh = !st && !fl && !m_second && p[1] && wide;
    chk({tag, " R2 addr"}, addr, ea);
    chk({tag, " R5 hold"}, {31'b0, hold}, {31'b0, eh});
    saw_hold = hold;
    e = last;
    if (fl) begin
      e = '{NOP, 1'b0, 1'b0}; m_second = 0; m_kept = '0;
    end else if (!st) begin
      if (m_second) begin
        e.i = {w[15:0], m_kept}; e.v = 1; m_second = 0;
      end else if (p[1]) begin
        if (wide) begin e = '{NOP, 1'b0, 1'b0}; m_kept = w[31:16]; m_second = 1; end
        else begin e.i = {16'h0, w[31:16]}; e.v = 1; end
      end else begin
        e.i = w; e.v = 1;
      end
      e.c = e.v && (e.i[1:0] != 2'b11);
    end
    last = e;
    q.push_back(e);
    tagq.push_back(tag);
  endtask

  // monitor
  always @(posedge clk) begin
    exp_t e;
    string t;
    #2;
    if (q.size() > 0) begin
      e = q.pop_front();
      t = tagq.pop_front();
      chk({t, " insn"}, insn, e.i);
      chk({t, " valid"}, {31'b0, vld}, {31'b0, e.v});
      chk({t, " R7 comp"}, {31'b0, comp}, {31'b0, e.c});
    end
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < 16; k++) mem[k] = (32'h1357_9BDF * (k + 1)) ^ 32'h0003_0003;
    mem[0] = 32'h0050_0113;
    mem[1] = 32'h4505_0513;   // upper half compressed
    mem[2] = 32'h0293_8082;   // upper half starts a wide insn, lower compressed
    mem[3] = 32'h1234_0040;   // upper half compressed
    mem[4] = 32'hAAAB_C0DE;   // upper half wide
    mem[5] = 32'h5555_8001;
    last = '{NOP, 1'b0, 1'b0};

    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    #1;
    chk("R1 reset insn", insn, NOP);
    chk("R1 reset valid", {31'b0, vld}, 32'd0);
    chk("R1 reset comp", {31'b0, comp}, 32'd0);
    chk("R1 reset hold", {31'b0, hold}, 32'd0);

    step(32'h0, 0, 0, "R3 aligned");
    step(32'h4, 0, 0, "R3 aligned");
    step(32'h8, 0, 0, "R3 aligned comp-low");
    step(32'h6, 0, 0, "R4 upper compressed");
    step(32'hA, 0, 0, "R5 split start");
    step(32'hA, 0, 0, "R6 split finish");
    step(32'hE, 0, 0, "R4 upper compressed");
    // flush on the completion cycle of a split
    step(32'hA, 0, 0, "R5 split start");
    step(32'hA, 0, 1, "R8 flush on second");
    step(32'hA, 0, 0, "R5 split again");
    step(32'hA, 0, 0, "R6 clean finish");
    // stall inside a split
    step(32'h12, 0, 0, "R5 split start");
    step(32'h12, 1, 0, "R9 stall mid split");
    step(32'h12, 1, 0, "R9 stall mid split");
    step(32'h12, 0, 0, "R6 finish after stall");
    // stall and flush together
    step(32'h4, 0, 0, "R3 aligned");
    step(32'h8, 1, 1, "R9 flush beats stall");
    step(32'h8, 1, 0, "R9 stall keeps bubble");
    step(32'hA, 0, 1, "R8 flush idle misaligned");
    // aligned throughput sweep
    for (int k = 0; k < 16; k++) step(32'(k * 4), 0, 0, "R3 sweep");
    // misaligned walk honoring hold requests
    for (int k = 0; k < 16; k++) begin
      step(32'(k * 4 + 2), 0, 0, "R4/R5 walk");
      if (saw_hold) step(32'(k * 4 + 2), 0, 0, "R6 walk");
    end
    step(32'h0, 0, 0, "R3 drain");
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule